// File: doc/BRIEF.md
# Masked chip-select decoder

This block decodes bus cycles into eight active-low chip-select lines. Seven of them are general channels and one is an upper channel. Each channel holds a 15-bit match value and a 15-bit mask. The value and mask are split into a ten-bit high half and a five-bit low half. Each channel also has a system-management qualifier with its own mask, an address-space select (memory or I/O) and an enable. On every address strobe, each channel compares the unmasked address bits against its programmed value. A set mask bit makes that address bit a don't-care. The compare takes different address lines for memory cycles and for I/O cycles. Each matching, enabled channel pulls its select low for one cycle. The channels act independently, with no priority between them.

Software programs the channels through a small 16-bit register port. Each channel owns an 8-byte window holding four registers. After reset the general channels are disabled. The upper channel starts enabled with every mask bit set, so it answers any memory cycle. This lets a boot memory respond before any register has been written.

Top module: `csel_decoder`

## Requirements
- R1: After reset, every `cs_n` bit is high until a strobe occurs. Each general channel's low mask register reads 0x0000. The upper channel (index 7) low mask register reads 0xFFFF and its high mask register reads 0x03FF. The upper channel asserts on any memory strobe and on no I/O strobe.
- R2: A register's byte address is channel*8 + offset. The offsets are: 0 high value (bits 9:0), 2 high mask (bits 9:0), 4 low value, 6 low mask. In the low value register, bits 15:11 hold the match value, bit 10 holds the required SMM state and bit 1 selects the space (1 = I/O). In the low mask register, bits 15:11 hold the mask, bit 10 masks the SMM qualifier and bit 0 enables the channel. Read data appears one cycle after `reg_re` and is zero in any cycle that follows no read.
- R3: Every bit outside the fields in R2 reads as zero. For the upper channel's low mask register, bits 9:1 read as ones only until that register is first written.
- R4: A mask bit of 1 makes the paired address bit a don't-care. A mask bit of 0 requires the address bit to equal the programmed value bit. This holds in both halves.
- R5: On a memory cycle (`bus_is_io`=0), the low half is compared with address bits 15:11 and the high half with bits 25:16.
- R6: On an I/O cycle, the low half is compared with address bits 5:1 and the high half with bits 15:6. A channel answers only cycles of the space it selects.
- R7: With the SMM mask bit at 0, a match also requires `bus_smm` to equal the programmed SMM bit. With the SMM mask bit at 1, `bus_smm` has no effect.
- R8: A channel whose enable bit is 0 never drives its select low.
- R9: A select goes low in the cycle after a clock edge that sampled `bus_ads` high with a match. It is high in every cycle after an edge where `bus_ads` was low.
- R10: Several channels that match the same strobe all assert together.
- R11: A register write in the same cycle as a strobe does not affect that strobe's decode. The write takes effect from the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Register byte address (channel*8 + offset) |
| reg_wdata | input | 16 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_rdata | output | 16 | Registered read data |
| bus_ads | input | 1 | Address strobe, one cycle per bus cycle |
| bus_addr | input | 26 | Bus address |
| bus_is_io | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| bus_smm | input | 1 | Processor is in system-management mode |
| cs_n | output | 8 | Active-low selects, bit 7 is the upper channel |

## Verification
A register write and an address strobe can land on the same clock edge. The case of interest is a write that changes the enable or mask of the channel being decoded. The bench drives a write that enables a disabled channel in the same cycle as a strobe that would match it. It expects that strobe to see the old configuration and the following strobe to see the new one. The scoreboard computes each expected select vector from its own shadow copy of the registers, and that copy is updated only after the collision cycle.

// File: rtl/csel_pkg.sv
package csel_pkg;

  localparam int LOW_W      = 5;
  localparam int HIGH_W     = 10;
  localparam int WORD_W     = 16;
  localparam int MEM_LO_LSB = 11;
  localparam int IO_LO_LSB  = 1;
  localparam int ADDR_W     = MEM_LO_LSB + LOW_W + HIGH_W;

  // register offsets inside a channel window (word index, byte offset / 2)
  localparam logic [1:0] OFS_HI_VAL = 2'd0;
  localparam logic [1:0] OFS_HI_MSK = 2'd1;
  localparam logic [1:0] OFS_LO_VAL = 2'd2;
  localparam logic [1:0] OFS_LO_MSK = 2'd3;

  // bit positions in the low registers
  localparam int FLD_LSB  = WORD_W - LOW_W;
  localparam int BIT_SMM  = 10;
  localparam int BIT_IO   = 1;
  localparam int BIT_EN   = 0;

  typedef struct packed {
    logic [HIGH_W-1:0] hi_val;
    logic [HIGH_W-1:0] hi_msk;
    logic [LOW_W-1:0]  lo_val;
    logic [LOW_W-1:0]  lo_msk;
    logic              smm_val;
    logic              smm_msk;
    logic              io_space;
    logic              enable;
  } chan_cfg_t;

  localparam chan_cfg_t CFG_GEN_RST = '0;
  localparam chan_cfg_t CFG_TOP_RST = '{
    hi_val: '0, hi_msk: '1, lo_val: '0, lo_msk: '1,
    smm_val: 1'b0, smm_msk: 1'b1, io_space: 1'b0, enable: 1'b1};

  function automatic logic [WORD_W-1:0] fmt_hi(input logic [HIGH_W-1:0] v);
    return {{(WORD_W-HIGH_W){1'b0}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] fmt_lo_val(input chan_cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[WORD_W-1:FLD_LSB] = c.lo_val;
    w[BIT_SMM]          = c.smm_val;
    w[BIT_IO]           = c.io_space;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] fmt_lo_msk(input chan_cfg_t c, input logic rsv);
    logic [WORD_W-1:0] w;
    w = {WORD_W{rsv}};
    w[WORD_W-1:FLD_LSB] = c.lo_msk;
    w[BIT_SMM]          = c.smm_msk;
    w[BIT_EN]           = c.enable;
    return w;
  endfunction

endpackage

// File: rtl/csel_regfile.sv
module csel_regfile
  import csel_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int RA_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [WORD_W-1:0] reg_rdata,
  output chan_cfg_t         cfg [NCH]
);

  localparam int CH_W = RA_W - 3;

  logic [CH_W-1:0]   sel_ch;
  logic [1:0]        sel_ofs;
  logic [WORD_W-1:0] rd_word [NCH];
  logic [WORD_W-1:0] rd_mux;
  logic              unused_byte_lane;

  assign sel_ch           = reg_addr[RA_W-1:3];
  assign sel_ofs          = reg_addr[2:1];
  assign unused_byte_lane = reg_addr[0];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    localparam bit IS_TOP = (ch == NCH - 1);
    chan_cfg_t c_q;
    logic      rsv_q;
    logic      wr_hit;

    assign wr_hit = reg_we && (sel_ch == CH_W'(ch));

    always_ff @(posedge clk) begin
      if (rst) begin
        c_q   <= IS_TOP ? CFG_TOP_RST : CFG_GEN_RST;
        rsv_q <= IS_TOP;
      end else if (wr_hit) begin
        case (sel_ofs)
          OFS_HI_VAL: c_q.hi_val <= reg_wdata[HIGH_W-1:0];
          OFS_HI_MSK: c_q.hi_msk <= reg_wdata[HIGH_W-1:0];
          OFS_LO_VAL: begin
            c_q.lo_val   <= reg_wdata[WORD_W-1:FLD_LSB];
            c_q.smm_val  <= reg_wdata[BIT_SMM];
            c_q.io_space <= reg_wdata[BIT_IO];
          end
          default: begin
            c_q.lo_msk  <= reg_wdata[WORD_W-1:FLD_LSB];
            c_q.smm_msk <= reg_wdata[BIT_SMM];
            c_q.enable  <= reg_wdata[BIT_EN];
            rsv_q       <= 1'b0;
          end
        endcase
      end
    end

    assign cfg[ch] = c_q;

    always_comb begin
      case (sel_ofs)
        OFS_HI_VAL: rd_word[ch] = fmt_hi(c_q.hi_val);
        OFS_HI_MSK: rd_word[ch] = fmt_hi(c_q.hi_msk);
        OFS_LO_VAL: rd_word[ch] = fmt_lo_val(c_q);
        default:    rd_word[ch] = fmt_lo_msk(c_q, rsv_q);
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCH; i++) begin
      if (sel_ch == CH_W'(i)) rd_mux = rd_word[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= reg_re ? rd_mux : '0;
  end

endmodule

// File: rtl/csel_chan_match.sv
module csel_chan_match
  import csel_pkg::*;
(
  input  chan_cfg_t         cfg,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_is_io,
  input  logic              bus_smm,
  output logic              hit
);

  logic [HIGH_W-1:0] hi_fld;
  logic [LOW_W-1:0]  lo_fld;
  logic              hi_ok, lo_ok, smm_ok, space_ok;
  logic              unused_addr_lsb;

  assign unused_addr_lsb = bus_addr[0];

  always_comb begin
    if (bus_is_io) begin
      lo_fld = bus_addr[IO_LO_LSB +: LOW_W];
      hi_fld = bus_addr[IO_LO_LSB + LOW_W +: HIGH_W];
    end else begin
      lo_fld = bus_addr[MEM_LO_LSB +: LOW_W];
      hi_fld = bus_addr[MEM_LO_LSB + LOW_W +: HIGH_W];
    end
  end

  assign hi_ok    = ((hi_fld ^ cfg.hi_val) & ~cfg.hi_msk) == '0;
  assign lo_ok    = ((lo_fld ^ cfg.lo_val) & ~cfg.lo_msk) == '0;
  assign smm_ok   = cfg.smm_msk || (bus_smm == cfg.smm_val);
  assign space_ok = (bus_is_io == cfg.io_space);
  assign hit      = cfg.enable && space_ok && smm_ok && hi_ok && lo_ok;

endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
  import csel_pkg::*;
#(
  parameter  int NUM_GEN = 7,
  localparam int NCH     = NUM_GEN + 1,
  localparam int RA_W    = $clog2(NCH) + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              bus_ads,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_is_io,
  input  logic              bus_smm,
  output logic [NCH-1:0]    cs_n
);

  chan_cfg_t        cfg [NCH];
  logic [NCH-1:0]   hit;

  csel_regfile #(.NCH(NCH), .RA_W(RA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_rdata (reg_rdata),
    .cfg       (cfg)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_match
    csel_chan_match u_match (
      .cfg       (cfg[ch]),
      .bus_addr  (bus_addr),
      .bus_is_io (bus_is_io),
      .bus_smm   (bus_smm),
      .hit       (hit[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) cs_n <= '1;
    else     cs_n <= bus_ads ? ~hit : '1;
  end

endmodule

// File: rtl/csel_decoder_chk.sv
module csel_decoder_chk
  import csel_pkg::*;
#(
  parameter  int NUM_GEN = 7,
  localparam int NCH     = NUM_GEN + 1,
  localparam int RA_W    = $clog2(NCH) + 3
) (
  input logic              clk,
  input logic              rst,
  input logic [RA_W-1:0]   reg_addr,
  input logic              reg_re,
  input logic [WORD_W-1:0] reg_rdata,
  input logic              bus_ads,
  input logic [NCH-1:0]    cs_n
);

  // R1: first cycle after reset, all selects idle and no read data
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cs_n == '1 && reg_rdata == '0));

  // R9: no strobe on the previous edge means no select now
  assert_no_strobe_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_ads) |-> cs_n == '1);

  // R2: read data is zero after a cycle without a read
  assert_rdata_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_re) |-> reg_rdata == '0);

  // R3: reserved bits of a low value register read zero
  assert_lo_val_rsv_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_re) && $past(reg_addr[2:1]) == OFS_LO_VAL)
      |-> (reg_rdata[BIT_SMM-1:BIT_IO+1] == '0 && !reg_rdata[0]));

  // R3: upper bits of the high registers read zero
  assert_hi_rsv_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_re) && !$past(reg_addr[2]))
      |-> reg_rdata[WORD_W-1:HIGH_W] == '0);

endmodule

bind csel_decoder csel_decoder_chk #(.NUM_GEN(NUM_GEN)) chk_i (.*);

// File: tb/csel_decoder_tb_top.sv
`timescale 1ns/1ps
module csel_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [15:0] reg_rdata;
  logic        bus_ads = 1'b0;
  logic [25:0] bus_addr = '0;
  logic        bus_is_io = 1'b0;
  logic        bus_smm = 1'b0;
  logic [7:0]  cs_n;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  csel_decoder dut_i (.*);

  // shadow configuration built from the requirements
  logic [9:0] m_hiv [8];
  logic [9:0] m_him [8];
  logic [4:0] m_lov [8];
  logic [4:0] m_lom [8];
  logic       m_smv [8];
  logic       m_smm [8];
  logic       m_io  [8];
  logic       m_en  [8];

  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 8; c++) begin
      m_hiv[c] = '0; m_him[c] = '0; m_lov[c] = '0; m_lom[c] = '0;
      m_smv[c] = 0;  m_smm[c] = 0;  m_io[c] = 0;   m_en[c] = 0;
    end
    m_him[7] = '1; m_lom[7] = '1; m_smm[7] = 1; m_en[7] = 1;
  endtask

  task automatic model_write(input logic [5:0] a, input logic [15:0] d);
    int c;
    c = int'(a[5:3]);
    case (a[2:1])
      2'd0: m_hiv[c] = d[9:0];
      2'd1: m_him[c] = d[9:0];
      2'd2: begin m_lov[c] = d[15:11]; m_smv[c] = d[10]; m_io[c] = d[1]; end
      default: begin m_lom[c] = d[15:11]; m_smm[c] = d[10]; m_en[c] = d[0]; end
    endcase
  endtask

  function automatic logic [7:0] model_cs(input logic [25:0] a, input logic io, input logic smm);
    logic [7:0] cs;
    logic [9:0] hf;
    logic [4:0] lf;
    cs = '1;
    hf = io ? a[15:6] : a[25:16];
    lf = io ? a[5:1]  : a[15:11];
    for (int c = 0; c < 8; c++) begin
      if (m_en[c] && m_io[c] == io && ((hf ^ m_hiv[c]) & ~m_him[c]) == '0 &&
          ((lf ^ m_lov[c]) & ~m_lom[c]) == '0 && (m_smm[c] || smm == m_smv[c]))
        cs[c] = 1'b0;
    end
    return cs;
  endfunction

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
    reg_addr = a; reg_re = 1'b1;
    @(negedge clk);
    reg_re = 1'b0;
    check(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  // driver: pushes the expected select vector, then drives one strobe
  task automatic strobe(input logic [25:0] a, input logic io, input logic smm, input string tag);
    exp_q.push_back(model_cs(a, io, smm));
    tag_q.push_back(tag);
    bus_addr = a; bus_is_io = io; bus_smm = smm; bus_ads = 1'b1;
    @(negedge clk);
    bus_ads = 1'b0;
  endtask

  // R11: register write and strobe on the same edge
  task automatic strobe_with_write(input logic [25:0] a, input logic [5:0] ra,
                                   input logic [15:0] d, input string tag);
    exp_q.push_back(model_cs(a, 1'b0, 1'b0));
    tag_q.push_back(tag);
    bus_addr = a; bus_is_io = 1'b0; bus_smm = 1'b0; bus_ads = 1'b1;
    reg_addr = ra; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    bus_ads = 1'b0; reg_we = 1'b0;
    model_write(ra, d);
  endtask

  // monitor
  logic ads_q = 1'b0;
  logic rst_q = 1'b1;
  always @(posedge clk) begin
    ads_q <= bus_ads;
    rst_q <= rst;
  end

  always @(negedge clk) begin
    if (!rst_q) begin
      if (ads_q) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected strobe result", {8'h0, cs_n}, 16'h0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(cs_n === e, t, {8'h0, cs_n}, {8'h0, e});
        end
      end else begin
        check(cs_n === 8'hFF, "R9 idle", {8'h0, cs_n}, 16'h00FF);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  localparam logic [25:0] A0 = {10'h155, 5'b10110, 11'h000};

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n === 8'hFF, "R1 reset cs_n", {8'h0, cs_n}, 16'h00FF);

    // R1 reset register values
    rd(6'd6,        16'h0000, "R1 gen low mask");
    rd(6'd7*8 + 6,  16'hFFFF, "R1 upper low mask");
    rd(6'd7*8 + 2,  16'h03FF, "R1 upper high mask");
    @(negedge clk);
    check(reg_rdata === 16'h0000, "R2 rdata zero without read", reg_rdata, 16'h0000);
    strobe(26'h0123456, 1'b0, 1'b0, "R1 upper answers memory");
    strobe(26'h0000086, 1'b1, 1'b0, "R1 upper ignores io");

    // channel 0: memory, low bit 11 masked, SMM masked, reserved bits set on write
    wr(6'd0, 16'h0155);
    wr(6'd2, 16'h0000);
    wr(6'd4, 16'hB000);
    wr(6'd6, 16'h0DFF);
    rd(6'd6, 16'h0C01, "R3 reserved mask bits read zero");
    rd(6'd4, 16'hB000, "R2 low value readback");
    wr(6'd4, 16'hB3FC);
    rd(6'd4, 16'hB000, "R3 reserved value bits read zero");
    wr(6'd0, 16'hFD55);
    rd(6'd0, 16'h0155, "R3 high register upper bits zero");
    strobe(A0,                      1'b0, 1'b0, "R5 ch0 exact match");
    strobe(A0 | 26'h0000800,        1'b0, 1'b1, "R4 masked bit ignored");
    strobe(A0 ^ 26'h0001000,        1'b0, 1'b0, "R4 unmasked low bit differs");
    strobe(A0 ^ 26'h0200000,        1'b0, 1'b0, "R5 high half differs");
    strobe(A0 | 26'h00007FF,        1'b0, 1'b0, "R5 bits below 11 ignored");

    // channel 1: I/O space, SMM must be 0
    wr(6'd8,  16'h0002);
    wr(6'd12, 16'h1802);
    wr(6'd14, 16'h0001);
    strobe(26'h0000086, 1'b1, 1'b0, "R6 io match");
    strobe(26'h0000086, 1'b0, 1'b0, "R6 memory cycle on io channel");
    strobe(26'h0000084, 1'b1, 1'b0, "R6 io low half differs");
    strobe(26'h0000086, 1'b1, 1'b1, "R7 smm required clear");

    // channel 2: memory, every address bit masked, SMM must be 1
    wr(6'd16 + 2, 16'h03FF);
    wr(6'd16 + 4, 16'h0400);
    wr(6'd16 + 6, 16'hF801);
    strobe(26'h2000000, 1'b0, 1'b1, "R7 smm required set, present");
    strobe(26'h2000000, 1'b0, 1'b0, "R7 smm required set, absent");

    // channel 3: everything masked, then overlap with ch0 and upper
    wr(6'd24 + 2, 16'h03FF);
    wr(6'd24 + 6, 16'hFC01);
    strobe(A0, 1'b0, 1'b0, "R10 three channels together");
    wr(6'd24 + 6, 16'hFC00);
    strobe(A0, 1'b0, 1'b0, "R8 disabled channel silent");

    // R11 write enabling ch3 in the strobe cycle
    strobe_with_write(A0, 6'd24 + 6, 16'hFC01, "R11 old config on collision");
    strobe(A0, 1'b0, 1'b0, "R11 new config next strobe");

    // R3 upper reserved image clears on write; back-to-back strobes for R9
    wr(6'd7*8 + 6, 16'hFFFF);
    rd(6'd7*8 + 6, 16'hFC01, "R3 upper reserved after write");
    strobe(26'h0000800, 1'b0, 1'b0, "R9 back to back first");
    strobe(26'h3FFF800, 1'b0, 1'b0, "R9 back to back second");
    repeat (3) @(negedge clk);

    check(exp_q.size() == 0, "R9 scoreboard drained", 16'(exp_q.size()), 16'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule